// File: doc/BRIEF.md
# Fractional NCO Time-of-Day Counter

This block keeps a free-running nanosecond time of day for precision time protocol work. On every cycle of its reference clock (nominally 125 MHz) a programmable fixed-point increment is added to a 72-bit phase accumulator. The top 44 bits of the accumulator are the integer nanosecond time and the lower 28 bits are a fraction. The nominal increment is 8.0 ns per tick. Software trims the rate by moving the increment a few units above or below nominal. An increment of zero stops time.

Software reaches the block through a minimal 32-bit register port with four word registers. These hold the lowest nanosecond nibble, the middle 32 time bits, the top time byte and the increment. A time load is staged. The lowest nibble and the middle word are held in shadow registers, and the write to the top-byte register moves all 44 bits into the accumulator on one clock edge. A time read is coherent when software reads the top-byte register first. That read freezes a snapshot of the lower 36 bits, and the following reads of the middle and low registers return the snapshot. The live integer time is also brought out directly for local use.

Top module: `tod_nco_counter`

## Requirements
- R1: While `rst_ni` is low, the time, the fraction, the read snapshot, the staged load values and `rdata_o` are all zero, and the increment is 0x8000_0000. After reset, a read of the increment register returns 0x8000_0000.
- R2: On every clock edge without a commit, the 32-bit increment is added to the 72-bit accumulator as an unsigned fixed-point value with 28 fraction bits. 0x8000_0000 advances time by exactly 8 ns per edge. Larger values run fast and smaller values run slow.
- R3: Carries out of the 28 fraction bits reach the integer time on the same edge. For example, an increment of 0x0800_0000 adds 1 ns every second edge.
- R4: While the increment is zero and no commit occurs, `time_ns_o` does not change.
- R5: A write to word 0 (`addr_i`=0, byte offset 0x00) stores `wdata_i[3:0]` in the staged low nibble. A write to word 1 (`addr_i`=1, byte 0x04) stores `wdata_i[31:0]` in the staged middle word. Neither write changes the running time.
- R6: A write to word 2 (`addr_i`=2, byte 0x08) loads the accumulator on that edge with integer time {`wdata_i[15:8]`, staged middle, staged low} and a zero fraction. The load replaces that edge's advance, and the other data bits are ignored.
- R7: A read of word 2 returns time bits [43:36] in `rdata_o[7:0]`, with zeros above. On the same edge it stores a snapshot of time bits [35:0].
- R8: A read of word 1 returns snapshot bits [35:4]. A read of word 0 returns snapshot bits [3:0] in `rdata_o[3:0]`, with zeros above. Neither read uses the live time.
- R9: The integer time wraps modulo 2^44, so a count past 0xFFF_FFFF_FFFF continues from zero.
- R10: `rdata_o` is registered. It updates on the edge at which `rd_en_i` is high, using the time as it stood before that edge, and it holds its value on every other edge.
- R11: A write to word 3 (`addr_i`=3, byte 0x0C) sets the increment. The new value first acts on the following edge, and a read of word 3 returns the current increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Word select, byte address bits [3:2] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| time_ns_o | output | 44 | Live integer nanosecond time |

## Verification
The commit of a staged time load and the regular increment step both land on the same accumulator edge, and the load must win and wipe the fraction. The bench provokes this by committing while the counter runs at 0.5 ns per edge with a half nanosecond pending. It expects the loaded value unchanged one cycle later and a single nanosecond added after the next edge. A second collision is a coherent read against a moving counter. The top-byte read is taken from a running count and the lower words are read tens of cycles later, and they must match the time sampled at the snapshot edge rather than the live value.

// File: rtl/tod_nco_pkg.sv
package tod_nco_pkg;
  // Word select on addr_i (byte address bits [3:2])
  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_MID = 2'd1,
    SEL_TOP = 2'd2,
    SEL_INC = 2'd3
  } reg_sel_e;

  localparam int unsigned NS_W_DEF     = 44;
  localparam int unsigned FRAC_W_DEF   = 28;
  localparam int unsigned DW_DEF       = 32;
  localparam int unsigned LO_W_DEF     = 4;
  localparam int unsigned TOP_WR_LSB_DEF = 8;
  localparam logic [31:0] INC_RST_DEF  = 32'h8000_0000;
endpackage

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
  parameter int unsigned NS_W   = 44,
  parameter int unsigned FRAC_W = 28,
  parameter int unsigned INC_W  = 32,
  localparam int unsigned ACC_W = NS_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [INC_W-1:0]  inc_i,
  input  logic              load_i,
  input  logic [NS_W-1:0]   load_ns_i,
  output logic [NS_W-1:0]   ns_o
);
  logic [FRAC_W-1:0] frac_q;
  logic [NS_W-1:0]   ns_q;
  logic [FRAC_W:0]   frac_sum;
  logic [NS_W-1:0]   inc_int;

  // integer part of the increment, zero-extended into the time width
  generate
    if (INC_W > FRAC_W) begin : g_int
      assign inc_int = NS_W'(inc_i[INC_W-1:FRAC_W]);
    end else begin : g_noint
      assign inc_int = '0;
    end
  endgenerate

  // fraction carry feeds the integer add on the same edge
  assign frac_sum = {1'b0, frac_q} + {1'b0, inc_i[FRAC_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frac_q <= '0;
      ns_q   <= '0;
    end else if (load_i) begin
      frac_q <= '0;
      ns_q   <= load_ns_i;
    end else begin
      frac_q <= frac_sum[FRAC_W-1:0];
      ns_q   <= ns_q + inc_int + NS_W'(frac_sum[FRAC_W]);
    end
  end

  assign ns_o = ns_q;
endmodule

// File: rtl/tod_load_stage.sv
module tod_load_stage #(
  parameter int unsigned NS_W       = 44,
  parameter int unsigned DW         = 32,
  parameter int unsigned LO_W       = 4,
  parameter int unsigned TOP_WR_LSB = 8,
  localparam int unsigned TOP_W     = NS_W - LO_W - DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_lo_i,
  input  logic            wr_mid_i,
  input  logic            wr_top_i,
  input  logic [DW-1:0]   wdata_i,
  output logic            commit_o,
  output logic [NS_W-1:0] commit_ns_o
);
  logic [LO_W-1:0] lo_q;
  logic [DW-1:0]   mid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q  <= '0;
      mid_q <= '0;
    end else begin
      if (wr_lo_i)  lo_q  <= wdata_i[LO_W-1:0];
      if (wr_mid_i) mid_q <= wdata_i;
    end
  end

  // top write carries its byte in a shifted lane
  assign commit_o    = wr_top_i;
  assign commit_ns_o = {wdata_i[TOP_WR_LSB +: TOP_W], mid_q, lo_q};
endmodule

// File: rtl/tod_rate_reg.sv
module tod_rate_reg #(
  parameter int unsigned DW      = 32,
  parameter logic [DW-1:0] INC_RST = 32'h8000_0000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] inc_o
);
  logic [DW-1:0] inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   inc_q <= INC_RST;
    else if (wr_i) inc_q <= wdata_i;
  end

  assign inc_o = inc_q;
endmodule

// File: rtl/tod_read_port.sv
module tod_read_port
  import tod_nco_pkg::*;
#(
  parameter int unsigned NS_W = 44,
  parameter int unsigned DW   = 32,
  parameter int unsigned LO_W = 4,
  localparam int unsigned TOP_W  = NS_W - LO_W - DW,
  localparam int unsigned SNAP_W = LO_W + DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rd_en_i,
  input  reg_sel_e        sel_i,
  input  logic [NS_W-1:0] ns_i,
  input  logic [DW-1:0]   inc_i,
  output logic [DW-1:0]   rdata_o
);
  logic [SNAP_W-1:0] snap_q;
  logic [DW-1:0]     rd_mux;
  logic [DW-1:0]     rdata_q;
  logic              snap_take;

  assign snap_take = rd_en_i && (sel_i == SEL_TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (snap_take) snap_q <= ns_i[SNAP_W-1:0];
  end

  always_comb begin
    unique case (sel_i)
      SEL_LO:  rd_mux = DW'(snap_q[LO_W-1:0]);
      SEL_MID: rd_mux = snap_q[SNAP_W-1:LO_W];
      SEL_TOP: rd_mux = DW'(ns_i[NS_W-1 -: TOP_W]);
      default: rd_mux = inc_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/tod_nco_counter.sv
module tod_nco_counter
  import tod_nco_pkg::*;
#(
  parameter int unsigned NS_W       = NS_W_DEF,
  parameter int unsigned FRAC_W     = FRAC_W_DEF,
  parameter int unsigned DW         = DW_DEF,
  parameter int unsigned LO_W       = LO_W_DEF,
  parameter int unsigned TOP_WR_LSB = TOP_WR_LSB_DEF,
  parameter logic [DW-1:0] INC_RST  = INC_RST_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [3:2]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic [NS_W-1:0] time_ns_o
);
  reg_sel_e        sel;
  logic            commit_w;
  logic [NS_W-1:0] commit_ns_w;
  logic [DW-1:0]   inc_w;
  logic [NS_W-1:0] ns_w;

  assign sel = reg_sel_e'(addr_i);

  tod_load_stage #(
    .NS_W(NS_W), .DW(DW), .LO_W(LO_W), .TOP_WR_LSB(TOP_WR_LSB)
  ) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_lo_i     (wr_en_i && sel == SEL_LO),
    .wr_mid_i    (wr_en_i && sel == SEL_MID),
    .wr_top_i    (wr_en_i && sel == SEL_TOP),
    .wdata_i     (wdata_i),
    .commit_o    (commit_w),
    .commit_ns_o (commit_ns_w)
  );

  tod_rate_reg #(.DW(DW), .INC_RST(INC_RST)) u_rate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && sel == SEL_INC),
    .wdata_i (wdata_i),
    .inc_o   (inc_w)
  );

  tod_phase_acc #(.NS_W(NS_W), .FRAC_W(FRAC_W), .INC_W(DW)) u_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc_w),
    .load_i    (commit_w),
    .load_ns_i (commit_ns_w),
    .ns_o      (ns_w)
  );

  tod_read_port #(.NS_W(NS_W), .DW(DW), .LO_W(LO_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (rd_en_i),
    .sel_i   (sel),
    .ns_i    (ns_w),
    .inc_i   (inc_w),
    .rdata_o (rdata_o)
  );

  assign time_ns_o = ns_w;
endmodule

// File: rtl/tod_nco_chk.sv
module tod_nco_chk #(
  parameter int unsigned NS_W       = 44,
  parameter int unsigned DW         = 32,
  parameter int unsigned TOP_W      = 8,
  parameter int unsigned TOP_WR_LSB = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [3:2]      addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic [DW-1:0]   rdata_o,
  input logic [NS_W-1:0] time_ns_o,
  input logic [DW-1:0]   inc_w
);
  logic commit;
  assign commit = wr_en_i && (addr_i == 2'd2);

  AST_COMMIT_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> time_ns_o[NS_W-1 -: TOP_W] == $past(wdata_i[TOP_WR_LSB +: TOP_W])); // R6
  AST_ZERO_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_w == '0) && !commit |=> $stable(time_ns_o)); // R4
  AST_STAGE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (addr_i == 2'd0 || addr_i == 2'd1) && (inc_w == '0) |=> $stable(time_ns_o)); // R5
  AST_NOMINAL_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_w == 32'h8000_0000) && !commit |=> time_ns_o == $past(time_ns_o) + NS_W'(8)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o)); // R10
  AST_TOP_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == 2'd2) |=> rdata_o == DW'($past(time_ns_o[NS_W-1 -: TOP_W]))); // R7
  AST_INC_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (addr_i == 2'd3) |=> rdata_o == $past(inc_w)); // R11
endmodule

bind tod_nco_counter tod_nco_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_en_i   (rd_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .time_ns_o (time_ns_o),
  .inc_w     (inc_w)
);

// File: tb/tod_nco_counter_tb_top.sv
`timescale 1ns/1ps
module tod_nco_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en, rd_en;
  logic [3:2]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [43:0] time_ns;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  tod_nco_counter dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .time_ns_o(time_ns)
  );

  typedef struct packed {
    logic [31:0] inc;
    logic [43:0] load;
    logic [7:0]  cyc;
    logic [3:0]  tag;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h8000_0000, 44'd0,              8'd10, 4'd2},
    '{32'h0800_0000, 44'd100,            8'd7,  4'd3},
    '{32'h8000_0064, 44'd1000,           8'd20, 4'd2},
    '{32'h7FFF_FF00, 44'h012_3456_789A,  8'd15, 4'd2},
    '{32'h0000_0000, 44'hABC_DEF0_1234,  8'd12, 4'd4},
    '{32'hFFFF_FFFF, 44'hFFF_FFFF_FFEC,  8'd3,  4'd9}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic load_time(input logic [43:0] t);
    bus_wr(2'd0, {28'hFFF_FFFF, t[3:0]});
    bus_wr(2'd1, t[35:4]);
    bus_wr(2'd2, {16'hFFFF, t[43:36], 8'h5A});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] rd;
    logic [43:0] t;
    logic [71:0] acc;
    rst_ni = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 time in reset", 72'(time_ns), 72'd0);
    check("R1 rdata in reset", 72'(rdata), 72'd0);
    rst_ni = 1'b1;
    bus_rd(2'd3, rd);
    check("R1 increment reset", 72'(rd), 72'h8000_0000);
    bus_rd(2'd0, rd);
    check("R1 snapshot reset", 72'(rd), 72'd0);

    // rate table
    foreach (VECS[i]) begin
      bus_wr(2'd3, VECS[i].inc);
      load_time(VECS[i].load);
      repeat (VECS[i].cyc) @(negedge clk);
      acc = {VECS[i].load, 28'd0} + 72'(VECS[i].cyc) * 72'(VECS[i].inc);
      check(tag_name(VECS[i].tag), 72'(time_ns), 72'(acc[71:28]));
    end

    // R5/R6 staging with frozen time
    bus_wr(2'd3, 32'd0);
    load_time(44'hA51_2345_6789);
    check("R6 commit frozen", 72'(time_ns), 72'hA51_2345_6789);
    bus_wr(2'd0, 32'h0000_0003);
    bus_wr(2'd1, 32'hDEAD_BEEF);
    check("R5 staged writes quiet", 72'(time_ns), 72'hA51_2345_6789);
    bus_wr(2'd2, 32'h0000_0000);
    check("R6 commit staged", 72'(time_ns), 72'h00D_EADB_EEF3);

    // R11 increment timing
    bus_wr(2'd3, 32'h8000_0000);
    check("R11 old increment on write edge", 72'(time_ns), 72'h00D_EADB_EEF3);
    @(negedge clk);
    check("R11 new increment next edge", 72'(time_ns), 72'h00D_EADB_EEF3 + 72'd8);
    bus_rd(2'd3, rd);
    check("R11 increment readback", 72'(rd), 72'h8000_0000);

    // R6 commit colliding with a pending half nanosecond
    bus_wr(2'd3, 32'h0800_0000);
    repeat (3) @(negedge clk);
    load_time(44'h000_0000_1000);
    check("R6 load replaces step", 72'(time_ns), 72'h1000);
    @(negedge clk);
    check("R6 fraction cleared", 72'(time_ns), 72'h1000);
    @(negedge clk);
    check("R3 carry after two halves", 72'(time_ns), 72'h1001);

    // R7/R8 coherent read on running count
    bus_wr(2'd3, 32'h8000_0000);
    load_time(44'hFED_CBA9_8765);
    repeat (5) @(negedge clk);
    t = time_ns;
    bus_rd(2'd2, rd);
    check("R7 top byte", 72'(rd), 72'(t[43:36]));
    repeat (30) @(negedge clk);
    bus_rd(2'd1, rd);
    check("R8 middle from snapshot", 72'(rd), 72'(t[35:4]));
    bus_rd(2'd0, rd);
    check("R8 low from snapshot", 72'(rd), 72'(t[3:0]));
    repeat (5) @(negedge clk);
    check("R10 rdata holds", 72'(rdata), 72'(t[3:0]));

    // R1 asynchronous reset mid-run
    bus_wr(2'd3, 32'd0);
    rst_ni = 1'b0;
    #1;
    check("R1 async clear", 72'(time_ns), 72'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    bus_rd(2'd3, rd);
    check("R1 increment restored", 72'(rd), 72'h8000_0000);

    done = 1'b1;
    finish_run();
  end
endmodule